// File: doc/BRIEF.md
# Sixteen-Source Prioritized Interrupt Controller

This block gathers sixteen interrupt request lines from peripherals. It records a rising edge on any of them as a pending bit, and offers the most urgent serviceable source to the processor as a 4-bit vector number with a request flag. Each pending bit lasts until the processor takes its vector or software clears it. This holds even while the source is masked or interrupts are globally locked out, so no event is lost during a critical section.

Software reaches the pending and enable bits through four byte-wide registers on a simple register bus. The low eight sources live at one pending/enable pair of addresses and the high eight at another, non-adjacent pair. Writing the pending registers lets software clear stale requests or raise interrupts of its own.

A hold-off input from the processor marks read-modify-write cycles. While it is high, no request is offered and acknowledges have no effect. This keeps a software clear of a pending bit from racing the hardware's own acknowledge clear. Sources selected by a parameter (by default only source 15, the non-maskable one) are serviced whatever the global enable input says.

Top module: `irq_prio16`

## Requirements
- R1: After reset, all pending bits and all enable bits are 0, `reqOut` is 0 and `vecOut` is 0.
- R2: A 0-to-1 change on `irqIn[i]` between two clock edges sets pending bit i at the next edge, whatever the enable bit and `globalEnable` hold. A level held high does not set the bit again after it has been cleared.
- R3: Reads are combinational. Address 0x09 returns pending bits 7..0, 0x12 returns pending bits 15..8, 0x08 returns enable bits 7..0 and 0x13 returns enable bits 15..8, with source i at bit i mod 8. Any other address reads 0x00. A write to any other address changes no register.
- R4: A write to a pending register replaces its eight bits with the written byte. A 1 raises a software interrupt and a 0 clears a pending one.
- R5: A source is eligible only when its pending bit and its enable bit (1 = enabled) are both set. Writes to the enable registers replace all eight bits.
- R6: `vecOut` is the highest index among eligible sources (15 most urgent, 0 least). It is 0 when none is eligible.
- R7: While `globalEnable` is 0, sources outside the non-maskable set are not eligible, but their pending bits are kept. Once it returns to 1, they are offered in priority order.
- R8: Source 15 (default non-maskable set) is eligible regardless of `globalEnable`, as long as its pending and enable bits are set.
- R9: `ackIn` high at a clock edge while `reqOut` is high clears the pending bit of the source shown on `vecOut`. With `reqOut` low, `ackIn` is ignored.
- R10: While `rmwHold` is 1, `reqOut` is 0 and `ackIn` clears nothing.
- R11: When a rising edge on `irqIn[i]` coincides with a clear of bit i by a software write or by an acknowledge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Interrupt request lines, rising-edge detected |
| globalEnable | input | 1 | Global enable for maskable sources |
| regAddr | input | 8 | Register bus byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| ackIn | input | 1 | Processor takes the offered vector |
| rmwHold | input | 1 | Read-modify-write hold-off |
| reqOut | output | 1 | An eligible source is offered |
| vecOut | output | 4 | Index of the offered source |

## Verification
The bench drives a behavioural model alongside the design and compares every output and the addressed read data on each clock. It aims at a coincident request edge and clear: a design that let the clear win would silently drop an interrupt. It also tests a held request level after a clear, where a level-sensitive design would re-raise the request without end. An acknowledge under the hold-off input would wrongly erase a pending bit, and the bench looks for that. Lockout is tested with both a maskable and a non-maskable source, which catches a design that gates source 15 with the global enable or lets maskable sources through. Writes to an unused address between the two register pairs expose a loose address decode.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC   = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = NUM_SRC / BYTE_W;
  localparam int VEC_W     = $clog2(NUM_SRC);

  typedef struct packed {
    logic wrPendLo;
    logic wrPendHi;
    logic wrMaskLo;
    logic wrMaskHi;
    logic ackTake;
  } intcStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PEND_LO,
    RD_PEND_HI,
    RD_MASK_LO,
    RD_MASK_HI
  } rdSel_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_MASK_LO = 8'h08,
  parameter logic [ADDR_W-1:0] ADDR_PEND_LO = 8'h09,
  parameter logic [ADDR_W-1:0] ADDR_PEND_HI = 8'h12,
  parameter logic [ADDR_W-1:0] ADDR_MASK_HI = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              ackIn,
  input  logic              rmwHold,
  input  logic              anyEligible,
  output intcStrobe_t       strobe,
  output rdSel_t            rdSel,
  output logic              reqOut
);
  always_comb begin
    if (regAddr == ADDR_PEND_LO)      rdSel = RD_PEND_LO;
    else if (regAddr == ADDR_PEND_HI) rdSel = RD_PEND_HI;
    else if (regAddr == ADDR_MASK_LO) rdSel = RD_MASK_LO;
    else if (regAddr == ADDR_MASK_HI) rdSel = RD_MASK_HI;
    else                              rdSel = RD_NONE;
  end

  assign reqOut = anyEligible && !rmwHold;

  always_comb begin
    strobe          = '0;
    strobe.wrPendLo = regWrEn && (rdSel == RD_PEND_LO);
    strobe.wrPendHi = regWrEn && (rdSel == RD_PEND_HI);
    strobe.wrMaskLo = regWrEn && (rdSel == RD_MASK_LO);
    strobe.wrMaskHi = regWrEn && (rdSel == RD_MASK_HI);
    strobe.ackTake  = ackIn && reqOut;
  end

  // R10: an acknowledge under hold-off never becomes a clear strobe
  assert_hold_blocks_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    rmwHold |-> !strobe.ackTake);
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] NMI_SET = 16'h8000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               globalEnable,
  input  logic [BYTE_W-1:0]  regWrData,
  input  intcStrobe_t        strobe,
  input  rdSel_t             rdSel,
  output logic [BYTE_W-1:0]  regRdData,
  output logic               anyEligible,
  output logic [VEC_W-1:0]   topIdx
);
  logic [NUM_SRC-1:0]   irqPrev, edgeVec, pendAll, maskAll, nextPend;
  logic [NUM_SRC-1:0]   ackClr, gateVec, eligible;
  logic [NUM_BYTES-1:0] wrPend, wrMask;

  assign wrPend  = {strobe.wrPendHi, strobe.wrPendLo};
  assign wrMask  = {strobe.wrMaskHi, strobe.wrMaskLo};
  assign edgeVec = irqIn & ~irqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqIn;
  end

  always_comb begin
    ackClr = '0;
    if (strobe.ackTake) ackClr[topIdx] = 1'b1;
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    // hardware edge is OR-ed last so it wins over any clear
    assign nextPend[b*BYTE_W +: BYTE_W] =
      ((wrPend[b] ? regWrData : pendAll[b*BYTE_W +: BYTE_W])
       & ~ackClr[b*BYTE_W +: BYTE_W]) | edgeVec[b*BYTE_W +: BYTE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendAll[b*BYTE_W +: BYTE_W] <= '0;
        maskAll[b*BYTE_W +: BYTE_W] <= '0;
      end else begin
        pendAll[b*BYTE_W +: BYTE_W] <= nextPend[b*BYTE_W +: BYTE_W];
        if (wrMask[b]) maskAll[b*BYTE_W +: BYTE_W] <= regWrData;
      end
    end
  end

  assign gateVec  = globalEnable ? '1 : NMI_SET;
  assign eligible = pendAll & maskAll & gateVec;

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (eligible[i]) topIdx = VEC_W'(i);
  end
  assign anyEligible = |eligible;

  always_comb begin
    case (rdSel)
      RD_PEND_LO: regRdData = pendAll[0 +: BYTE_W];
      RD_PEND_HI: regRdData = pendAll[BYTE_W +: BYTE_W];
      RD_MASK_LO: regRdData = maskAll[0 +: BYTE_W];
      RD_MASK_HI: regRdData = maskAll[BYTE_W +: BYTE_W];
      default:    regRdData = '0;
    endcase
  end

  // R2: every detected edge is latched regardless of mask or lockout
  assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rstN)
    (edgeVec != '0) |=> ((pendAll & $past(edgeVec)) == $past(edgeVec)));

  // R9: a taken vector loses its pending bit unless re-raised or rewritten
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackTake && !edgeVec[topIdx] && !wrPend[topIdx[VEC_W-1]])
      |=> !pendAll[$past(topIdx)]);

  // R6: nothing eligible sits above the offered index
  assert_top_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyEligible |-> ((eligible >> topIdx) == 16'd1));

  // R3: enable bits move only on a decoded enable write
  assert_mask_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrMask == '0) |=> $stable(maskAll));
endmodule

// File: rtl/irq_prio16.sv
module irq_prio16
  import intc_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] ADDR_MASK_LO = 8'h08,
  parameter logic [ADDR_W-1:0] ADDR_PEND_LO = 8'h09,
  parameter logic [ADDR_W-1:0] ADDR_PEND_HI = 8'h12,
  parameter logic [ADDR_W-1:0] ADDR_MASK_HI = 8'h13,
  parameter logic [15:0]       NMI_SET      = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       irqIn,
  input  logic              globalEnable,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              ackIn,
  input  logic              rmwHold,
  output logic              reqOut,
  output logic [3:0]        vecOut
);
  intcStrobe_t strobe;
  rdSel_t      rdSel;
  logic        anyEligible;

  intc_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_MASK_LO(ADDR_MASK_LO), .ADDR_PEND_LO(ADDR_PEND_LO),
    .ADDR_PEND_HI(ADDR_PEND_HI), .ADDR_MASK_HI(ADDR_MASK_HI)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .ackIn(ackIn), .rmwHold(rmwHold), .anyEligible(anyEligible),
    .strobe(strobe), .rdSel(rdSel), .reqOut(reqOut)
  );

  intc_dp #(.NMI_SET(NMI_SET)) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .globalEnable(globalEnable),
    .regWrData(regWrData), .strobe(strobe), .rdSel(rdSel),
    .regRdData(regRdData), .anyEligible(anyEligible), .topIdx(vecOut)
  );

  // R10: hold-off suppresses the request at the port
  assert_hold_no_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    rmwHold |-> !reqOut);

  // R7: under lockout only non-maskable sources may raise a request
  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEnable && vecOut != 4'd15) |-> !reqOut);
endmodule

// File: tb/irq_prio16_tb.sv
`timescale 1ns/1ps
module irq_prio16_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic        globalEnable = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        ackIn = 1'b0;
  logic        rmwHold = 1'b0;
  logic        reqOut;
  logic [3:0]  vecOut;

  int vectors = 0;
  int miscompares = 0;

  bit mPend[16];
  bit mMask[16];
  bit mPrev[16];

  always #10 clk = ~clk;

  irq_prio16 dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .globalEnable(globalEnable),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ackIn(ackIn), .rmwHold(rmwHold),
    .reqOut(reqOut), .vecOut(vecOut)
  );

  function automatic bit eligibleSrc(int i);
    return mPend[i] && mMask[i] && (globalEnable || i == 15);
  endfunction

  function automatic int expVec();
    int v = 0;
    for (int i = 0; i < 16; i++) if (eligibleSrc(i)) v = i;
    return v;
  endfunction

  function automatic bit expReq();
    bit any = 0;
    for (int i = 0; i < 16; i++) if (eligibleSrc(i)) any = 1;
    return any && !rmwHold;
  endfunction

  function automatic logic [7:0] packByte(bit arr[16], int base);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = arr[base + i];
    return r;
  endfunction

  function automatic logic [7:0] expRd();
    case (regAddr)
      8'h09: return packByte(mPend, 0);
      8'h12: return packByte(mPend, 8);
      8'h08: return packByte(mMask, 0);
      8'h13: return packByte(mMask, 8);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // called just after a falling edge; compares, then advances the model at the rising edge
  task automatic tick(string tag);
    bit ackEff;
    int v;
    #5;
    check(tag, "reqOut", int'(reqOut), int'(expReq()));
    check(tag, "vecOut", int'(vecOut), expVec());
    check(tag, "regRdData", int'(regRdData), int'(expRd()));
    v = expVec();
    ackEff = ackIn && expReq();
    @(posedge clk);
    if (rstN) begin
      for (int i = 0; i < 16; i++) begin
        bit np = mPend[i];
        if (regWrEn && regAddr == 8'h09 && i < 8)  np = regWrData[i];
        if (regWrEn && regAddr == 8'h12 && i >= 8) np = regWrData[i-8];
        if (ackEff && v == i) np = 0;
        if (irqIn[i] && !mPrev[i]) np = 1;
        mPend[i] = np;
        if (regWrEn && regAddr == 8'h08 && i < 8)  mMask[i] = regWrData[i];
        if (regWrEn && regAddr == 8'h13 && i >= 8) mMask[i] = regWrData[i-8];
        mPrev[i] = irqIn[i];
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick(tag);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    regAddr = a;
    tick(tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mPend[i] = 0; mMask[i] = 0; mPrev[i] = 0; end
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    // R1: reset state visible on all four registers and the request
    rd(8'h09, "R1"); rd(8'h12, "R1"); rd(8'h08, "R1"); rd(8'h13, "R1");

    // R2: edge latched while masked and locked out
    irqIn[3] = 1'b1; rd(8'h09, "R2"); rd(8'h09, "R2");
    // R5: enabling makes it eligible
    globalEnable = 1'b1;
    wr(8'h08, 8'hFF, "R5"); rd(8'h08, "R5");
    // R6: higher source takes over
    wr(8'h13, 8'hFF, "R6");
    irqIn[10] = 1'b1; rd(8'h12, "R6"); rd(8'h12, "R6");
    // R9: acknowledge clears the offered source, then next is offered
    ackIn = 1'b1; tick("R9"); ackIn = 1'b0; rd(8'h12, "R9");
    // R2: held high level does not re-pend after clear by write
    wr(8'h09, 8'h00, "R2"); rd(8'h09, "R2"); rd(8'h09, "R2");
    // R9: acknowledge with no request is ignored
    ackIn = 1'b1; tick("R9"); ackIn = 1'b0; rd(8'h09, "R9");

    // R7: lockout keeps maskable pending, no request
    globalEnable = 1'b0;
    irqIn[12] = 1'b1; rd(8'h12, "R7"); rd(8'h12, "R7");
    // R8: non-maskable source served under lockout
    irqIn[15] = 1'b1; rd(8'h12, "R8"); rd(8'h12, "R8");
    ackIn = 1'b1; tick("R8"); ackIn = 1'b0; rd(8'h12, "R8");
    // R7: re-enable releases the held source
    globalEnable = 1'b1; rd(8'h12, "R7");

    // R10: hold-off blocks request and acknowledge
    rmwHold = 1'b1; ackIn = 1'b1; tick("R10"); tick("R10");
    ackIn = 1'b0; rd(8'h12, "R10"); rmwHold = 1'b0; rd(8'h12, "R10");

    // R4: software clears and raises pending bits
    wr(8'h12, 8'h00, "R4"); rd(8'h12, "R4");
    wr(8'h12, 8'h40, "R4"); rd(8'h12, "R4");
    wr(8'h09, 8'h21, "R4"); rd(8'h09, "R4");

    // R11: edge coinciding with software clear
    irqIn[5] = 1'b0; irqIn[3] = 1'b0; tick("R11");
    irqIn[5] = 1'b1; wr(8'h09, 8'h00, "R11"); rd(8'h09, "R11");
    // R11: edge coinciding with acknowledge of the same source
    irqIn[14] = 1'b0; tick("R11");
    irqIn[14] = 1'b1; ackIn = 1'b1; tick("R11"); ackIn = 1'b0; rd(8'h12, "R11");

    // R3: write to an address between the pairs changes nothing
    wr(8'h10, 8'hFF, "R3"); wr(8'h0A, 8'h00, "R3");
    rd(8'h10, "R3"); rd(8'h09, "R3"); rd(8'h12, "R3"); rd(8'h08, "R3"); rd(8'h13, "R3");

    // R5/R6: partial mask walk over several patterns
    wr(8'h09, 8'hFF, "R6"); wr(8'h12, 8'hFF, "R6");
    for (int m = 0; m < 8; m++) begin
      wr(8'h13, 8'h00, "R5");
      wr(8'h08, 8'(1 << m) | 8'h01, "R6");
    end
    wr(8'h13, 8'h81, "R6"); globalEnable = 1'b0; rd(8'h13, "R8");
    globalEnable = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ackIn = 1'b1; tick("R9");
    end
    ackIn = 1'b0; rd(8'h09, "R9"); rd(8'h12, "R9");

    finishRun();
  end
endmodule